// File: doc/BRIEF.md
# Per-Channel Receive Timing Generator

The block follows the bit position inside a framed TDM receive stream and produces per-channel timing for logic downstream. It works in two frame structures: 24 channels of 8 bits plus one leading framing bit (193 bits per frame), or 32 channels of 8 bits (256 bits per frame). A single-cycle frame sync input marks the first bit of each frame. From then on the block counts bits freely and wraps at the end of each frame.

The block forms two per-channel signals. The channel clock marks the last bit of every slot, which is the LSB, because bits arrive MSB first. The channel block signal holds, for the full slot, a level taken from a 32-bit mask with one bit per channel. A select input chooses which of the two signals drives the single output pin. Typical uses are gating a serial controller to a subset of channels, finding a slot for drop-and-insert, and serial-to-parallel conversion. The integrator chooses the clock, either the recovered line clock or a system clock.

Top module: `rx_chan_timing`

## Requirements
- R1: While `rst_ni` is low, `chan_pin_o` is 0 whatever the other inputs do.
- R2: When `fsync_i` is high at a rising edge, `chan_pin_o` in the following cycle shows frame bit 0. The output is registered, so it always shows the bit that follows the latest edge.
- R3: With `e1_mode_i`=1 the frame is 256 bits. It holds channels 0..31 of 8 bits each, starting at bit 0, and the count wraps to bit 0 with no further sync.
- R4: With `e1_mode_i`=0 the frame is 193 bits. Bit 0 is a framing bit during which both signals are 0. Channel c occupies bits 1+8c to 8+8c, and the count wraps with no further sync.
- R5: The channel clock is 1 only during the eighth bit (the LSB) of each channel slot, which gives exactly one pulse per channel per frame.
- R6: The channel block signal equals `chan_mask_i[c]` for all eight bits of channel c.
- R7: With `e1_mode_i`=0, mask bits 31..24 have no effect on the output.
- R8: `out_sel_i`=1 routes the channel clock to `chan_pin_o`, and `out_sel_i`=0 routes the channel block signal.
- R9: A sync pulse at any bit position, including mid-frame, restarts the count at frame bit 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock (line or system clock) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Frame sync: the next bit is frame bit 0 |
| e1_mode_i | input | 1 | 1 = 32-channel frame, 0 = 24-channel frame with framing bit |
| out_sel_i | input | 1 | 1 = channel clock on pin, 0 = channel block |
| chan_mask_i | input | 32 | Per-channel block level, bit c for channel c |
| chan_pin_o | output | 1 | Selected per-channel timing output |

## Verification
A wrong slot or channel count shows at the pin within at most eight bits. The channel clock pulse moves off the slot boundary, or a mask level appears in the wrong slot. A framing bit that is missed or duplicated in the 24-channel mode shifts every later channel by one bit, and the first pulse after the framing bit shows the error. The bench compares every bit of whole frames, including wraps with no resync, against a position model. It does this for both frame types, both pin selections, varied masks and mid-frame resynchronization, so a one-bit slip is caught within the same frame.

// File: rtl/rxct_pkg.sv
package rxct_pkg;
  localparam int unsigned BITS_PER_CH = 8;
  localparam int unsigned T1_CH       = 24;
  localparam int unsigned E1_CH       = 32;
  localparam int unsigned MASK_W      = E1_CH;
  localparam int unsigned SLOT_W      = $clog2(BITS_PER_CH);
  localparam int unsigned CH_W        = $clog2(E1_CH);

  typedef struct packed {
    logic              fbit;
    logic [CH_W-1:0]   chan;
    logic [SLOT_W-1:0] slot;
  } pos_t;
endpackage

// File: rtl/rxct_frame_cnt.sv
module rxct_frame_cnt
  import rxct_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fsync_i,
  input  logic e1_mode_i,
  output pos_t pos_q_o,
  output pos_t pos_d_o
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(BITS_PER_CH - 1);
  localparam logic [CH_W-1:0]   T1_LAST   = CH_W'(T1_CH - 1);
  localparam logic [CH_W-1:0]   E1_LAST   = CH_W'(E1_CH - 1);

  pos_t pos_q, pos_d;
  logic [CH_W-1:0] chan_last;

  assign chan_last = e1_mode_i ? E1_LAST : T1_LAST;

  always_comb begin
    pos_d = pos_q;
    if (fsync_i) begin
      // sync: next bit is frame bit 0 (framing bit in 24-ch mode)
      pos_d.fbit = ~e1_mode_i;
      pos_d.chan = '0;
      pos_d.slot = '0;
    end else if (pos_q.fbit) begin
      pos_d.fbit = 1'b0;
      pos_d.chan = '0;
      pos_d.slot = '0;
    end else if (pos_q.slot == SLOT_LAST) begin
      pos_d.slot = '0;
      if (pos_q.chan >= chan_last) begin
        pos_d.chan = '0;
        pos_d.fbit = ~e1_mode_i;
      end else begin
        pos_d.chan = pos_q.chan + 1'b1;
      end
    end else begin
      pos_d.slot = pos_q.slot + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= pos_d;
  end

  assign pos_q_o = pos_q;
  assign pos_d_o = pos_d;

  assert_slot_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fsync_i && !pos_q.fbit && pos_q.slot == SLOT_LAST) |=> (pos_q.slot == '0));

  assert_sync_realign_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_i |=> (pos_q.slot == '0 && pos_q.chan == '0 && pos_q.fbit == !$past(e1_mode_i)));

  assert_t1_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fsync_i && !e1_mode_i && !pos_q.fbit && pos_q.chan == T1_LAST && pos_q.slot == SLOT_LAST)
    |=> pos_q.fbit);

  assert_fbit_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fsync_i && pos_q.fbit) |=> (!pos_q.fbit && pos_q.chan == '0 && pos_q.slot == '0));

  assert_e1_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fsync_i && e1_mode_i && !pos_q.fbit && pos_q.chan == E1_LAST && pos_q.slot == SLOT_LAST)
    |=> (!pos_q.fbit && pos_q.chan == '0 && pos_q.slot == '0));
endmodule

// File: rtl/rxct_strobe_gen.sv
module rxct_strobe_gen
  import rxct_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pos_t              pos_d_i,
  input  logic              e1_mode_i,
  input  logic              out_sel_i,
  input  logic [MASK_W-1:0] chan_mask_i,
  output logic              chclk_o,
  output logic              chblk_o,
  output logic              pin_o
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(BITS_PER_CH - 1);

  logic chclk_d, chblk_d, mask_ok;
  logic chclk_q, chblk_q, pin_q;

  // in 24-ch mode upper mask bits never reach the output
  assign mask_ok = e1_mode_i || (32'(pos_d_i.chan) < T1_CH);
  assign chclk_d = !pos_d_i.fbit && (pos_d_i.slot == SLOT_LAST);
  assign chblk_d = !pos_d_i.fbit && mask_ok && chan_mask_i[pos_d_i.chan];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chclk_q <= 1'b0;
      chblk_q <= 1'b0;
      pin_q   <= 1'b0;
    end else begin
      chclk_q <= chclk_d;
      chblk_q <= chblk_d;
      pin_q   <= out_sel_i ? chclk_d : chblk_d;
    end
  end

  assign chclk_o = chclk_q;
  assign chblk_o = chblk_q;
  assign pin_o   = pin_q;

  assert_pin_route_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sel_i |=> (pin_q == chclk_q));
endmodule

// File: rtl/rx_chan_timing.sv
module rx_chan_timing
  import rxct_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  input  logic              e1_mode_i,
  input  logic              out_sel_i,
  input  logic [MASK_W-1:0] chan_mask_i,
  output logic              chan_pin_o
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(BITS_PER_CH - 1);

  pos_t pos_q, pos_d;
  logic chclk, chblk;

  rxct_frame_cnt u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fsync_i   (fsync_i),
    .e1_mode_i (e1_mode_i),
    .pos_q_o   (pos_q),
    .pos_d_o   (pos_d)
  );

  rxct_strobe_gen u_strb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pos_d_i     (pos_d),
    .e1_mode_i   (e1_mode_i),
    .out_sel_i   (out_sel_i),
    .chan_mask_i (chan_mask_i),
    .chclk_o     (chclk),
    .chblk_o     (chblk),
    .pin_o       (chan_pin_o)
  );

  always_comb begin
    if (!rst_ni) assert_reset_quiet_R1: assert (chan_pin_o == 1'b0);
  end

  assert_fbit_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q.fbit |-> (!chclk && !chblk));

  assert_lsb_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chclk |-> (!pos_q.fbit && pos_q.slot == SLOT_LAST));
endmodule

// File: tb/rx_chan_timing_tb_top.sv
module rx_chan_timing_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync = 1'b0;
  logic        e1 = 1'b1;
  logic        sel = 1'b0;
  logic [31:0] mask = '0;
  logic        pin;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_chan_timing dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .fsync_i     (fsync),
    .e1_mode_i   (e1),
    .out_sel_i   (sel),
    .chan_mask_i (mask),
    .chan_pin_o  (pin)
  );

  function automatic logic exp_pin(logic m_e1, logic m_sel, logic [31:0] m_mask, int p);
    int q;
    if (!m_e1) begin
      if (p == 0) return 1'b0;
      q = p - 1;
    end else q = p;
    if (m_sel) return (q % 8) == 7;
    return m_mask[q / 8];
  endfunction

  task automatic check(string req, logic act, logic exp, int p);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s pos=%0d act=%b exp=%b", req, p, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // sync at the next edge; returns at the negedge where frame bit 0 is shown
  task automatic pulse_sync();
    @(negedge clk);
    fsync = 1'b1;
    @(negedge clk);
    fsync = 1'b0;
  endtask

  // checks nbits consecutive bits from frame bit 0; toggles sel every tog bits if tog>0
  task automatic run_bits(string req, int nbits, int tog);
    int flen;
    flen = e1 ? 256 : 193;
    pulse_sync();
    for (int i = 0; i < nbits; i++) begin
      check(req, pin, exp_pin(e1, sel, mask, i % flen), i % flen);
      if (tog > 0 && (i % tog) == tog - 1) sel = ~sel;
      @(negedge clk);
    end
  endtask

  task automatic test_reset_R1();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      fsync = i[0];
      sel   = i[1];
      mask  = '1;
      check("R1", pin, 1'b0, i);
    end
    fsync = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic test_e1_clock_R5();
    e1 = 1'b1; sel = 1'b1; mask = '0;
    run_bits("R5/R3/R2", 2 * 256 + 10, 0);
  endtask

  task automatic test_e1_block_R6();
    e1 = 1'b1; sel = 1'b0; mask = 32'hA5C3_0F81;
    run_bits("R6/R3", 256 + 20, 0);
    mask = 32'h8000_0001;
    run_bits("R6", 256, 0);
  endtask

  task automatic test_t1_clock_R4();
    e1 = 1'b0; sel = 1'b1; mask = '1;
    run_bits("R4/R5/R2", 2 * 193 + 10, 0);
  endtask

  task automatic test_t1_block_R7();
    e1 = 1'b0; sel = 1'b0; mask = 32'hFF5A_3C81;
    run_bits("R7/R6/R4", 2 * 193 + 5, 0);
    mask = 32'hFF00_0000;
    run_bits("R7", 193, 0);
  endtask

  task automatic test_select_R8();
    e1 = 1'b1; sel = 1'b0; mask = 32'h3333_CCCC;
    run_bits("R8", 300, 5);
    e1 = 1'b0; sel = 1'b1; mask = 32'h00F0_F00F;
    run_bits("R8", 200, 3);
  endtask

  task automatic test_realign_R9();
    e1 = 1'b1; sel = 1'b1; mask = 32'h0000_FFFF;
    run_bits("R9", 50, 0);
    run_bits("R9", 270, 0);
    e1 = 1'b0; sel = 1'b0; mask = 32'h0055_AA55;
    run_bits("R9", 77, 0);
    run_bits("R9", 200, 0);
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    summary();
    $finish;
  end

  initial begin
    test_reset_R1();
    test_e1_clock_R5();
    test_e1_block_R6();
    test_t1_clock_R4();
    test_t1_block_R7();
    test_select_R8();
    test_realign_R9();
    summary();
    $finish;
  end
endmodule